// File: doc/BRIEF.md
# Parallel Microprocessor Bus Slave Port

This block connects an 8-bit microprocessor bus to a 32-address register file. One strap input picks the strobe style: Intel style, with separate active-low read and write strobes, or Motorola style, with one data strobe and a read/write direction line. A second strap picks the bus arrangement. Either the address travels on the data bus and is latched by an address strobe, or it arrives on a separate 5-bit address bus. Every bus input passes through a two-flop synchroniser into the system clock domain. All edges are detected on the synchronised copies, so the bus timing is independent of the system clock.

Read data is driven back through a data output with a separate output enable, so the pad ring forms the bidirectional bus. A handshake output with its own enable acknowledges each access. In Intel style it is released while the part is not selected, driven low once selected and driven high once the transfer completes. In Motorola style it is always driven: low when idle, high once an address is received, and low again after the transfer. Only the lowest `REG_COUNT` addresses have storage.

Top module: `hostbus_par_port`

## Requirements
- R1: After reset, `d_oe` is 0, the handshake is released in Intel style (`hs_oe` = 0), and every implemented register reads 0.
- R2: With `fmt_intel` = 1, `ds_wr_n` is the active-low write strobe and `rw_rd_n` is the active-low read strobe. A write stores the data bus at the rising edge of the write strobe, and a read returns the stored byte.
- R3: With `fmt_intel` = 0, `ds_wr_n` is the active-low data strobe and `rw_rd_n` gives the direction (1 = read, 0 = write). A write commits at the rising edge of the data strobe.
- R4: With `bus_mux` = 1, the address is taken from bits 4:0 of the data bus and held from the falling edge of `as_ale`; bits 7:5 of that byte are ignored. With `bus_mux` = 0, `adr` supplies the address.
- R5: `d_oe` is 1 while a selected read strobe is active, and it returns to 0 after the read strobe is released, while chip select is still low.
- R6: A write to an address at or above `REG_COUNT` is ignored, and a read from such an address returns 0.
- R7: In Intel style, `hs_oe` follows selection. Once selected, `hs_out` is 0 until the transfer completes and 1 afterwards, and a new address strobe returns it to 0.
- R8: In Motorola style, `hs_oe` is always 1. `hs_out` is 0 when idle. It is 1 once the address is received (at selection with `bus_mux` = 0, at the address-strobe fall with `bus_mux` = 1), and it returns to 0 after the transfer completes.
- R9: Strobes while `cs_n` is high write nothing and drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_intel | input | 1 | 1 = Intel strobes, 0 = Motorola strobes |
| bus_mux | input | 1 | 1 = address on data bus, 0 = separate address bus |
| cs_n | input | 1 | Active-low chip select |
| adr | input | ADDR_W | Separate address bus |
| d_in | input | DATA_W | Data bus, inbound |
| d_out | output | DATA_W | Data bus, outbound read data |
| d_oe | output | 1 | Data bus output enable |
| ds_wr_n | input | 1 | Write strobe (Intel) or data strobe (Motorola), active low |
| rw_rd_n | input | 1 | Read strobe, active low (Intel) or direction line (Motorola) |
| as_ale | input | 1 | Address strobe, latching on its falling edge |
| hs_out | output | 1 | Handshake level |
| hs_oe | output | 1 | Handshake output enable |

## Verification
The bench builds the block with its default parameters: 8-bit data, 5-bit addresses, two synchroniser stages, and 24 implemented registers. Because `REG_COUNT` is below the 32-entry address space, the top eight addresses are unimplemented, so the dropped-write and zero-read paths can be reached with the last implemented address right beside them. All four strobe and bus variants are exercised, and the handshake is checked at selection, after the address phase, after the transfer and after deselection.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

   // Synchronised copy of the bus control pins
   typedef struct packed {
      logic cs_n;
      logic dsw_n;
      logic rwr;
      logic as;
   } strb_t;

   localparam strb_t STRB_IDLE = '{cs_n: 1'b1, dsw_n: 1'b1, rwr: 1'b1, as: 1'b0};

endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   initial assert (STAGES >= 2) else $fatal(1, "hostbus_sync needs at least two stages");

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/hostbus_regfile.sv
module hostbus_regfile #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned REG_COUNT = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   initial assert (REG_COUNT >= 1 && REG_COUNT <= DEPTH)
      else $fatal(1, "REG_COUNT must lie within the address space");

   logic [DATA_W-1:0] word [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i < REG_COUNT) begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
               word[i] <= wr_data;
         end
      end else begin : g_empty
         assign word[i] = '0;
      end
   end

   assign rd_data = word[rd_addr];

   // Unimplemented slots always read back as zero
   p_unimpl_zero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rd_addr) >= REG_COUNT) |-> (rd_data == '0));

endmodule

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
   import hostbus_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fmt_intel,
   input  logic              bus_mux,
   input  strb_t             strb,
   input  logic [DATA_W-1:0] d_s,
   input  logic [ADDR_W-1:0] a_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] d_out,
   output logic              d_oe,
   output logic              hs_out,
   output logic              hs_oe
);

   initial assert (DATA_W >= ADDR_W) else $fatal(1, "address must fit the data bus");

   logic              sel, strb_on, rd_act, wr_cap, as_q, as_fall, rd_end;
   logic              wr_pend, addr_ok, done;
   logic [ADDR_W-1:0] lat_addr, addr_eff;

   assign sel     = ~strb.cs_n;
   assign strb_on = ~strb.dsw_n;
   assign rd_act  = sel & (fmt_intel ? ~strb.rwr : (strb_on & strb.rwr));
   assign wr_cap  = sel & strb_on & ~rd_act & (fmt_intel | ~strb.rwr);
   assign as_fall = bus_mux & as_q & ~strb.as;
   assign addr_eff = bus_mux ? lat_addr : a_s;
   assign rd_addr  = addr_eff;

   // Address latch: tracks the bus while the address strobe is high,
   // holding the last value from the falling edge on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_q     <= 1'b0;
         lat_addr <= '0;
      end else begin
         as_q <= strb.as;
         if (strb.as) lat_addr <= d_s[ADDR_W-1:0];
      end
   end

   // Write capture: sample while the strobe is held, commit on its release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pend <= 1'b0;
         wr_data <= '0;
         wr_addr <= '0;
      end else begin
         wr_pend <= wr_cap;
         if (wr_cap) begin
            wr_data <= d_s;
            wr_addr <= addr_eff;
         end
      end
   end

   assign wr_en = wr_pend & ~strb_on & sel;

   // Read drive
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_oe  <= 1'b0;
         d_out <= '0;
      end else begin
         d_oe  <= rd_act;
         d_out <= rd_act ? rd_data : '0;
      end
   end

   assign rd_end = d_oe & ~rd_act & sel;

   // Handshake state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_ok <= 1'b0;
         done    <= 1'b0;
      end else begin
         addr_ok <= sel & (addr_ok | (bus_mux ? as_fall : 1'b1));
         done    <= sel & (wr_en | rd_end | (done & ~as_fall));
      end
   end

   always_comb begin
      if (fmt_intel) begin
         hs_oe  = sel;
         hs_out = done;
      end else begin
         hs_oe  = 1'b1;
         hs_out = addr_ok & ~done;
      end
   end

   p_no_drive_on_write_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      d_oe |-> !wr_en);

   p_moto_idle_low_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!fmt_intel && !sel) |=> (fmt_intel || !hs_out));

   p_rdy_high_after_xfer_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_intel && wr_en) |=> (!fmt_intel || hs_out));

   p_write_needs_sel_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(sel));

endmodule

// File: rtl/hostbus_par_port.sv
module hostbus_par_port
   import hostbus_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned REG_COUNT   = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fmt_intel,
   input  logic              bus_mux,
   input  logic              cs_n,
   input  logic [ADDR_W-1:0] adr,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_out,
   output logic              d_oe,
   input  logic              ds_wr_n,
   input  logic              rw_rd_n,
   input  logic              as_ale,
   output logic              hs_out,
   output logic              hs_oe
);

   localparam int unsigned BUS_W = DATA_W + ADDR_W;

   strb_t             strb_raw, strb_s;
   logic [BUS_W-1:0]  bus_s;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, rd_data;

   assign strb_raw = '{cs_n: cs_n, dsw_n: ds_wr_n, rwr: rw_rd_n, as: as_ale};

   hostbus_sync #(.WIDTH($bits(strb_t)), .STAGES(SYNC_STAGES), .RST_VAL(STRB_IDLE)) u_sync_ctl (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (strb_raw),
      .dout (strb_s)
   );

   hostbus_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({d_in, adr}),
      .dout (bus_s)
   );

   hostbus_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt_intel(fmt_intel),
      .bus_mux  (bus_mux),
      .strb     (strb_s),
      .d_s      (bus_s[BUS_W-1:ADDR_W]),
      .a_s      (bus_s[ADDR_W-1:0]),
      .rd_data  (rd_data),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .d_out    (d_out),
      .d_oe     (d_oe),
      .hs_out   (hs_out),
      .hs_oe    (hs_oe)
   );

   hostbus_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   // Intel-style handshake is never driven while deselected (two sync stages of lag)
   p_rdy_released_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_intel && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !hs_oe);

endmodule

// File: tb/tb_hostbus_par_port.sv
module tb_hostbus_par_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fmt_intel = 1'b1;
   logic       bus_mux = 1'b0;
   logic       cs_n = 1'b1;
   logic [4:0] adr = '0;
   logic [7:0] d_in = '0;
   logic [7:0] d_out;
   logic       d_oe;
   logic       ds_wr_n = 1'b1;
   logic       rw_rd_n = 1'b1;
   logic       as_ale = 1'b0;
   logic       hs_out, hs_oe;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   hostbus_par_port dut (
      .clk(clk), .rst_n(rst_n), .fmt_intel(fmt_intel), .bus_mux(bus_mux),
      .cs_n(cs_n), .adr(adr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
      .ds_wr_n(ds_wr_n), .rw_rd_n(rw_rd_n), .as_ale(as_ale),
      .hs_out(hs_out), .hs_oe(hs_oe)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // One bus access in the current format and arrangement; handshake as {hs_oe, hs_out}
   task automatic xfer(input bit is_rd, input logic [7:0] a8, input logic [7:0] wdat, input bit cs_en,
                       output logic [7:0] rdat, output logic rd_oe, output logic oe_after,
                       output logic [1:0] hs_sel, output logic [1:0] hs_adr,
                       output logic [1:0] hs_done, output logic [1:0] hs_idle);
      adr     = a8[4:0];
      rw_rd_n = fmt_intel ? 1'b1 : is_rd;
      cs_n    = !cs_en;
      wait_cyc(6);
      hs_sel = {hs_oe, hs_out};
      hs_adr = hs_sel;
      if (bus_mux) begin
         d_in = a8; as_ale = 1'b1;
         wait_cyc(6);
         as_ale = 1'b0;
         wait_cyc(6);
         hs_adr = {hs_oe, hs_out};
      end
      d_in = is_rd ? 8'h00 : wdat;
      wait_cyc(2);
      if (fmt_intel && is_rd) rw_rd_n = 1'b0;
      else                    ds_wr_n = 1'b0;
      wait_cyc(6);
      rd_oe = d_oe;
      rdat  = d_out;
      ds_wr_n = 1'b1;
      if (fmt_intel) rw_rd_n = 1'b1;
      wait_cyc(6);
      oe_after = d_oe;
      hs_done  = {hs_oe, hs_out};
      cs_n = 1'b1; rw_rd_n = 1'b1; d_in = '0;
      wait_cyc(6);
      hs_idle = {hs_oe, hs_out};
   endtask

   task automatic wr(input logic [7:0] a8, input logic [7:0] v);
      logic [7:0] r; logic o1, o2; logic [1:0] h1, h2, h3, h4;
      xfer(1'b0, a8, v, 1'b1, r, o1, o2, h1, h2, h3, h4);
   endtask

   task automatic rd(input logic [7:0] a8, output logic [7:0] v);
      logic o1, o2; logic [1:0] h1, h2, h3, h4;
      xfer(1'b1, a8, 8'h00, 1'b1, v, o1, o2, h1, h2, h3, h4);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1", "d_oe after reset", {7'b0, d_oe}, 8'h00);
      chk("R1", "hs_oe after reset", {7'b0, hs_oe}, 8'h00);
      rd(8'h05, v);
      chk("R1", "register 5 after reset", v, 8'h00);
      rd(8'h17, v);
      chk("R1", "register 23 after reset", v, 8'h00);
   endtask

   task automatic t_intel_sep();
      logic [7:0] r; logic o1, o2; logic [1:0] hs, ha, hd, hi;
      fmt_intel = 1'b1; bus_mux = 1'b0;
      xfer(1'b0, 8'h10, 8'hA5, 1'b1, r, o1, o2, hs, ha, hd, hi);
      chk("R7", "rdy at selection", {6'b0, hs}, 8'h02);
      chk("R7", "rdy after write", {6'b0, hd}, 8'h03);
      chk("R7", "rdy released", {7'b0, hi[1]}, 8'h00);
      xfer(1'b1, 8'h10, 8'h00, 1'b1, r, o1, o2, hs, ha, hd, hi);
      chk("R2", "intel read data", r, 8'hA5);
      chk("R5", "oe during read", {7'b0, o1}, 8'h01);
      chk("R5", "oe after RD release", {7'b0, o2}, 8'h00);
      chk("R7", "rdy after read", {6'b0, hd}, 8'h03);
   endtask

   task automatic t_moto_sep();
      logic [7:0] r; logic o1, o2; logic [1:0] hs, ha, hd, hi;
      fmt_intel = 1'b0; bus_mux = 1'b0;
      wait_cyc(4);
      chk("R8", "ack idle", {6'b0, hs_oe, hs_out}, 8'h02);
      xfer(1'b0, 8'h03, 8'h3C, 1'b1, r, o1, o2, hs, ha, hd, hi);
      chk("R8", "ack after selection", {6'b0, hs}, 8'h03);
      chk("R8", "ack after write", {6'b0, hd}, 8'h02);
      chk("R8", "ack after deselect", {6'b0, hi}, 8'h02);
      xfer(1'b1, 8'h03, 8'h00, 1'b1, r, o1, o2, hs, ha, hd, hi);
      chk("R3", "motorola read data", r, 8'h3C);
      chk("R5", "oe during DS read", {7'b0, o1}, 8'h01);
      chk("R5", "oe after DS release", {7'b0, o2}, 8'h00);
      chk("R8", "ack after read", {6'b0, hd}, 8'h02);
   endtask

   task automatic t_intel_mux();
      logic [7:0] r; logic o1, o2; logic [1:0] hs, ha, hd, hi;
      fmt_intel = 1'b1; bus_mux = 1'b1;
      xfer(1'b0, 8'hE7, 8'h5A, 1'b1, r, o1, o2, hs, ha, hd, hi);
      chk("R7", "rdy after address phase", {6'b0, ha}, 8'h02);
      chk("R7", "rdy after mux write", {6'b0, hd}, 8'h03);
      rd(8'h07, r);
      chk("R4", "mux read of address 7", r, 8'h5A);
      bus_mux = 1'b0;
      rd(8'h07, r);
      chk("R4", "separate-bus read shows upper bits ignored", r, 8'h5A);
   endtask

   task automatic t_moto_mux_unimpl();
      logic [7:0] r; logic o1, o2; logic [1:0] hs, ha, hd, hi;
      fmt_intel = 1'b0; bus_mux = 1'b1;
      xfer(1'b0, 8'h17, 8'hC3, 1'b1, r, o1, o2, hs, ha, hd, hi);
      chk("R8", "ack before address strobe", {6'b0, hs}, 8'h02);
      chk("R8", "ack after address strobe", {6'b0, ha}, 8'h03);
      chk("R8", "ack after mux write", {6'b0, hd}, 8'h02);
      xfer(1'b0, 8'h1F, 8'h99, 1'b1, r, o1, o2, hs, ha, hd, hi);
      xfer(1'b0, 8'h18, 8'h77, 1'b1, r, o1, o2, hs, ha, hd, hi);
      rd(8'h17, r);
      chk("R6", "last implemented register", r, 8'hC3);
      rd(8'h1F, r);
      chk("R6", "unimplemented address 31 reads zero", r, 8'h00);
      rd(8'h18, r);
      chk("R6", "unimplemented address 24 reads zero", r, 8'h00);
   endtask

   task automatic t_unselected();
      logic [7:0] r; logic o1, o2; logic [1:0] hs, ha, hd, hi;
      fmt_intel = 1'b1; bus_mux = 1'b0;
      xfer(1'b0, 8'h10, 8'hFF, 1'b0, r, o1, o2, hs, ha, hd, hi);
      chk("R9", "rdy stays released", {6'b0, hd}, {6'b0, 1'b0, hd[0]});
      xfer(1'b1, 8'h10, 8'h00, 1'b0, r, o1, o2, hs, ha, hd, hi);
      chk("R9", "no drive without select", {7'b0, o1}, 8'h00);
      rd(8'h10, r);
      chk("R9", "register untouched by unselected write", r, 8'hA5);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_intel_sep();
      t_moto_sep();
      t_intel_mux();
      t_moto_mux_unimpl();
      t_unselected();
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule